// File: doc/BRIEF.md
# Unpack Destination Address Generator

This block produces one 16-byte-aligned destination address per output vector of an unpack transfer into a windowed vector memory. Two memory units are served. Each unit has its own window base and window size. A start strobe latches the transfer set-up: a 10-bit starting offset in 16-byte units, a flag that asks for the double-buffer top pointer to be added, the write-length and cycle-length fields, the current top pointer, the target unit and a vector count. After that, each cycle with the step enable high emits the next address.

The vector index term has two modes. When the cycle length is at least the write length, the generator skips: it writes a run of write-length vectors and then jumps forward by the cycle length. Otherwise it counts vectors one after another. The top pointer is added only on unit 1. Any address that runs past the end of the selected window is folded back into the window.

Top module: `unpack_addr_gen`

## Requirements
- R1: Each emitted address equals the selected unit's window base plus 16 times the wrapped sum of immAddr, the top term and the index term, so its low 4 bits are always zero.
- R2: When cycleLen >= writeLen (raw 8-bit compare), the index for output vector n is cycleLen*(n / W) + (n mod W), where W is the write length.
- R3: A writeLen of 0 acts as W = 256 in that division, and the compare of R2 then selects the skipping mode.
- R4: When cycleLen < writeLen, the index for output vector n is simply n.
- R5: With unitSel = 1 and addTop = 1, the top term is topsPtr. With unitSel = 0, addTop has no effect and the top term is 0.
- R6: A transfer emits exactly vecCount addresses, and a vecCount of 0 means 256.
- R7: The offset sum is reduced modulo the window size (4096 bytes for unit 0, 16384 bytes for unit 1, both parameters), so every address stays inside its window.
- R8: One address is emitted per rising edge at which busy and stepEn are both high. The address and addrValid appear after that edge. addrValid stays low after an edge where stepEn was low.
- R9: done is a one-cycle pulse that rises together with the last address of a transfer, and busy is low in that same cycle.
- R10: The set-up inputs are captured only when start is seen while idle. A start during a transfer is ignored, and the transfer continues with its original set-up.
- R11: After reset, addrValid, done and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer; accepted only while idle |
| vecCount | input | 8 | Number of vectors; 0 means 256 |
| immAddr | input | 10 | Starting offset in 16-byte units |
| addTop | input | 1 | Add the top pointer (unit 1 only) |
| writeLen | input | 8 | Write length; 0 means 256 |
| cycleLen | input | 8 | Cycle length |
| topsPtr | input | 10 | Double-buffer top pointer in 16-byte units |
| unitSel | input | 1 | Target unit: 0 or 1 |
| stepEn | input | 1 | Advance one vector this cycle |
| addrOut | output | 32 | Byte address of the current vector |
| addrValid | output | 1 | addrOut holds a new address |
| done | output | 1 | Last address of the transfer is on addrOut |
| busy | output | 1 | A transfer is in progress |

## Verification
A start takes effect at the rising edge where it is sampled, and busy is high after that edge. The address, addrValid and done for a step are registered once, so they appear after the rising edge that sampled stepEn high. The bench drives every input on the falling edge and reads the outputs on the next falling edge, which places each check exactly one register stage after its stimulus. Cycles with the enable low and ignored start pulses are checked the same way: addrValid must be low on the following falling edge, and the address sequence must pick up unchanged afterwards.

// File: rtl/unpack_addr_pkg.sv
package unpack_addr_pkg;

  // Strobes sent from the control sequencer to the address datapath
  typedef struct packed {
    logic loadCfg;   // latch set-up, clear index state
    logic advance;   // emit current address, move to next vector
    logic finish;    // this advance is the final vector
  } addrStrobe_t;

endpackage

// File: rtl/unpack_addr_ctrl.sv
module unpack_addr_ctrl
  import unpack_addr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] vecCount,
  input  logic             stepEn,
  output addrStrobe_t      strobe,
  output logic             busy,
  output logic             done
);

  localparam int REM_W = CNT_W + 1;

  logic             busyR;
  logic             doneR;
  logic [REM_W-1:0] remR;

  always_comb begin
    strobe.loadCfg = start & ~busyR;
    strobe.advance = busyR & stepEn;
    strobe.finish  = busyR & stepEn & (remR == REM_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR <= 1'b0;
      doneR <= 1'b0;
      remR  <= '0;
    end else begin
      doneR <= strobe.finish;
      if (strobe.loadCfg) begin
        busyR <= 1'b1;
        remR  <= (vecCount == '0) ? REM_W'(1 << CNT_W) : REM_W'(vecCount);
      end else if (strobe.advance) begin
        remR <= remR - REM_W'(1);
        if (strobe.finish) busyR <= 1'b0;
      end
    end
  end

  assign busy = busyR;
  assign done = doneR;

endmodule

// File: rtl/unpack_addr_dp.sv
module unpack_addr_dp
  import unpack_addr_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              IMM_W    = 10,
  parameter int              LEN_W    = 8,
  parameter logic [ADDR_W-1:0] U0_BASE  = 32'h0000_8000,
  parameter logic [ADDR_W-1:0] U1_BASE  = 32'h0001_0000,
  parameter int              U0_BYTES = 4096,
  parameter int              U1_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rstN,
  input  addrStrobe_t       strobe,
  input  logic [IMM_W-1:0]  immAddr,
  input  logic              addTop,
  input  logic [LEN_W-1:0]  writeLen,
  input  logic [LEN_W-1:0]  cycleLen,
  input  logic [IMM_W-1:0]  topsPtr,
  input  logic              unitSel,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic              unitLatched
);

  localparam int QW_SHIFT = 4;                 // 16-byte vectors
  localparam int WL_W     = LEN_W + 1;         // holds 2**LEN_W
  localparam int IDX_W    = 2 * LEN_W + 1;     // cycleLen * rows + inner
  localparam int SUM_W    = IDX_W + 2;         // imm + top + index

  // Captured set-up
  logic             unitR;
  logic             skipR;
  logic [IMM_W-1:0] immR;
  logic [IMM_W-1:0] topTermR;
  logic [WL_W-1:0]  wlEffR;
  logic [LEN_W-1:0] clR;

  // Incremental index state: replaces the divide and modulo per vector
  logic [WL_W-1:0]  innerR;
  logic [IDX_W-1:0] rowR;
  logic [IDX_W-1:0] idxR;

  logic [ADDR_W-1:0] addrR;
  logic              validR;

  logic [SUM_W-1:0]  sumQw;
  logic [ADDR_W-1:0] unitAddr [2];
  logic              rowEnd;
  logic [IDX_W-1:0]  nextRow;

  assign sumQw   = SUM_W'(immR) + SUM_W'(topTermR) + SUM_W'(idxR);
  assign rowEnd  = (innerR == wlEffR - WL_W'(1));
  assign nextRow = rowR + IDX_W'(clR);

  // Per-unit window fold; power-of-two windows use a mask, others a modulo
  for (genvar u = 0; u < 2; u++) begin : gWin
    localparam int              WIN_BYTES = (u == 0) ? U0_BYTES : U1_BYTES;
    localparam int              WIN_QW    = WIN_BYTES >> QW_SHIFT;
    localparam logic [ADDR_W-1:0] WIN_BASE = (u == 0) ? U0_BASE : U1_BASE;
    logic [SUM_W-1:0] foldQw;
    if ((WIN_QW & (WIN_QW - 1)) == 0) begin : gMask
      assign foldQw = sumQw & SUM_W'(WIN_QW - 1);
    end else begin : gMod
      assign foldQw = sumQw % SUM_W'(WIN_QW);
    end
    assign unitAddr[u] = WIN_BASE + (ADDR_W'(foldQw) << QW_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitR    <= 1'b0;
      skipR    <= 1'b0;
      immR     <= '0;
      topTermR <= '0;
      wlEffR   <= '0;
      clR      <= '0;
      innerR   <= '0;
      rowR     <= '0;
      idxR     <= '0;
      addrR    <= '0;
      validR   <= 1'b0;
    end else begin
      validR <= 1'b0;
      if (strobe.loadCfg) begin
        unitR    <= unitSel;
        skipR    <= (writeLen <= cycleLen);
        immR     <= immAddr;
        topTermR <= (unitSel & addTop) ? topsPtr : '0;
        wlEffR   <= (writeLen == '0) ? WL_W'(1 << LEN_W) : WL_W'(writeLen);
        clR      <= cycleLen;
        innerR   <= '0;
        rowR     <= '0;
        idxR     <= '0;
      end else if (strobe.advance) begin
        addrR  <= unitAddr[unitR];
        validR <= 1'b1;
        if (skipR && rowEnd) begin
          innerR <= '0;
          rowR   <= nextRow;
          idxR   <= nextRow;
        end else begin
          innerR <= innerR + WL_W'(1);
          idxR   <= idxR + IDX_W'(1);
        end
      end
    end
  end

  assign addrOut     = addrR;
  assign addrValid   = validR;
  assign unitLatched = unitR;

endmodule

// File: rtl/unpack_addr_gen.sv
module unpack_addr_gen
  import unpack_addr_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              IMM_W    = 10,
  parameter int              LEN_W    = 8,
  parameter int              CNT_W    = 8,
  parameter logic [ADDR_W-1:0] U0_BASE  = 32'h0000_8000,
  parameter logic [ADDR_W-1:0] U1_BASE  = 32'h0001_0000,
  parameter int              U0_BYTES = 4096,
  parameter int              U1_BYTES = 16384
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  vecCount,
  input  logic [IMM_W-1:0]  immAddr,
  input  logic              addTop,
  input  logic [LEN_W-1:0]  writeLen,
  input  logic [LEN_W-1:0]  cycleLen,
  input  logic [IMM_W-1:0]  topsPtr,
  input  logic              unitSel,
  input  logic              stepEn,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic              done,
  output logic              busy
);

  addrStrobe_t strobe;
  logic        unitLatched;

  unpack_addr_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .vecCount (vecCount),
    .stepEn   (stepEn),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  unpack_addr_dp #(
    .ADDR_W   (ADDR_W),
    .IMM_W    (IMM_W),
    .LEN_W    (LEN_W),
    .U0_BASE  (U0_BASE),
    .U1_BASE  (U1_BASE),
    .U0_BYTES (U0_BYTES),
    .U1_BYTES (U1_BYTES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .immAddr     (immAddr),
    .addTop      (addTop),
    .writeLen    (writeLen),
    .cycleLen    (cycleLen),
    .topsPtr     (topsPtr),
    .unitSel     (unitSel),
    .addrOut     (addrOut),
    .addrValid   (addrValid),
    .unitLatched (unitLatched)
  );

endmodule

// File: rtl/unpack_addr_chk.sv
module unpack_addr_chk #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] U0_BASE  = 32'h0000_8000,
  parameter logic [ADDR_W-1:0] U1_BASE  = 32'h0001_0000,
  parameter int              U0_BYTES = 4096,
  parameter int              U1_BYTES = 16384
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              stepEn,
  input logic              busy,
  input logic              done,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addrOut,
  input logic              unitLatched
);

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (addrOut[3:0] == 4'h0));

  assert_win0_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !unitLatched) |->
      (addrOut >= U0_BASE && addrOut < U0_BASE + ADDR_W'(U0_BYTES)));

  assert_win1_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && unitLatched) |->
      (addrOut >= U1_BASE && addrOut < U1_BASE + ADDR_W'(U1_BYTES)));

  assert_step_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> ($past(stepEn) && $past(busy)));

  assert_done_with_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (addrValid && !busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_unit_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(unitLatched));

endmodule

bind unpack_addr_gen unpack_addr_chk #(
  .ADDR_W   (ADDR_W),
  .U0_BASE  (U0_BASE),
  .U1_BASE  (U1_BASE),
  .U0_BYTES (U0_BYTES),
  .U1_BYTES (U1_BYTES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .stepEn      (stepEn),
  .busy        (busy),
  .done        (done),
  .addrValid   (addrValid),
  .addrOut     (addrOut),
  .unitLatched (unitLatched)
);

// File: tb/tb_unpack_addr_gen.sv
`timescale 1ns/1ps
module tb_unpack_addr_gen;

  localparam logic [31:0] BASE0 = 32'h0000_8000;
  localparam logic [31:0] BASE1 = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vecCount = '0;
  logic [9:0]  immAddr = '0;
  logic        addTop = 1'b0;
  logic [7:0]  writeLen = '0;
  logic [7:0]  cycleLen = '0;
  logic [9:0]  topsPtr = '0;
  logic        unitSel = 1'b0;
  logic        stepEn = 1'b0;
  logic [31:0] addrOut;
  logic        addrValid;
  logic        done;
  logic        busy;

  int nCompared = 0;
  int nMismatched = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  unpack_addr_gen dut (
    .clk(clk), .rstN(rstN), .start(start), .vecCount(vecCount),
    .immAddr(immAddr), .addTop(addTop), .writeLen(writeLen),
    .cycleLen(cycleLen), .topsPtr(topsPtr), .unitSel(unitSel),
    .stepEn(stepEn), .addrOut(addrOut), .addrValid(addrValid),
    .done(done), .busy(busy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected address straight from the requirement formulas
  function automatic logic [31:0] expAddr(bit unit, int imm, bit aTop, int wl,
                                          int cl, int tops, int n);
    int wle, idx, t, q, win;
    wle = (wl == 0) ? 256 : wl;
    idx = (wl <= cl) ? cl * (n / wle) + (n % wle) : n;
    t   = (unit && aTop) ? tops : 0;
    win = unit ? 1024 : 256;
    q   = (imm + t + idx) % win;
    return (unit ? BASE1 : BASE0) + 32'(q * 16);
  endfunction

  // One transfer; optional idle cycle at gapAt, with a stray start if junk
  task automatic runXfer(string req, bit unit, int imm, bit aTop, int wl, int cl,
                         int tops, int cnt, int gapAt, bit junk);
    int total;
    total = (cnt == 0) ? 256 : cnt;
    @(negedge clk);
    unitSel = unit; immAddr = 10'(imm); addTop = aTop; writeLen = 8'(wl);
    cycleLen = 8'(cl); topsPtr = 10'(tops); vecCount = 8'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " busy after start"}, 32'(busy), 32'd1);
    for (int n = 0; n < total; n++) begin
      if (n == gapAt) begin
        stepEn = 1'b0;
        if (junk) begin
          start = 1'b1; unitSel = ~unit; immAddr = 10'd333; writeLen = 8'd1;
          cycleLen = 8'd9; vecCount = 8'd2; addTop = 1'b1; topsPtr = 10'd77;
        end
        @(negedge clk);
        start = 1'b0;
        chk({req, " R8 no addr when idle step"}, 32'(addrValid), 32'd0);
      end
      stepEn = 1'b1;
      @(negedge clk);
      chk({req, " R8 valid"}, 32'(addrValid), 32'd1);
      chk({req, " R1 addr"}, addrOut, expAddr(unit, imm, aTop, wl, cl, tops, n));
      chk({req, " R9 done"}, 32'(done), 32'(n == total - 1));
    end
    stepEn = 1'b0;
    chk({req, " R6 R9 busy after last"}, 32'(busy), 32'd0);
    @(negedge clk);
    chk({req, " R6 no extra addr"}, 32'(addrValid), 32'd0);
    chk({req, " R9 done pulse"}, 32'(done), 32'd0);
  endtask

  task automatic testReset();
    chk("R11 valid", 32'(addrValid), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 busy", 32'(busy), 32'd0);
  endtask

  task automatic testIdleStep();
    // R8: enable with no transfer gives nothing
    @(negedge clk);
    stepEn = 1'b1;
    @(negedge clk);
    chk("R8 idle enable", 32'(addrValid), 32'd0);
    stepEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIdleStep();
    // R4 R5: linear, unit 1 with top pointer
    runXfer("R4 R5 linear unit1", 1'b1, 10, 1'b1, 4, 2, 20, 5, -1, 1'b0);
    // R2: skipping stride
    runXfer("R2 skip", 1'b1, 3, 1'b0, 2, 4, 0, 7, -1, 1'b0);
    // R2 equal lengths
    runXfer("R2 skip equal", 1'b0, 0, 1'b0, 3, 3, 0, 6, -1, 1'b0);
    // R5: unit 0 ignores add-top
    runXfer("R5 unit0 no top", 1'b0, 40, 1'b1, 1, 0, 50, 4, -1, 1'b0);
    // R7: unit 0 wrap
    runXfer("R7 wrap unit0", 1'b0, 250, 1'b0, 8, 1, 0, 10, -1, 1'b0);
    // R7: unit 1 wrap via top pointer
    runXfer("R7 wrap unit1", 1'b1, 1000, 1'b1, 2, 1, 900, 4, -1, 1'b0);
    // R7: skipping stride pushed past window end
    runXfer("R2 R7 skip wrap", 1'b0, 200, 1'b0, 2, 30, 0, 9, -1, 1'b0);
    // R3 R6: writeLen 0 and count 0
    runXfer("R3 R6 full count", 1'b1, 900, 1'b0, 0, 3, 0, 0, -1, 1'b0);
    // R8: gap in the enable
    runXfer("R8 gap", 1'b1, 5, 1'b0, 3, 5, 0, 8, 4, 1'b0);
    // R10: start during transfer ignored
    runXfer("R10 mid start", 1'b1, 7, 1'b1, 2, 3, 11, 6, 2, 1'b1);
    // single vector transfer
    runXfer("R6 R9 single", 1'b0, 17, 1'b0, 5, 0, 0, 1, -1, 1'b0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule